// File: doc/BRIEF.md
# Doubleword Shift Unit

This block is the shift stage of a 64-bit execution datapath. It is purely combinational. It takes a 4-bit operation code, the 64-bit value to be shifted, a 64-bit register value that can supply a shift distance, and a 5-bit immediate distance field. It returns the 64-bit result for the destination register.

Three shift kinds are supported: logical left, logical right and arithmetic right. Each kind has three ways of giving the distance:

- the immediate field on its own (0 to 31);
- the immediate field plus 32 (32 to 63);
- the low six bits of the register value (0 to 63).

A small decoder picks the kind and the distance source. The 6-bit effective distance then feeds one shared six-stage logarithmic shifter. A left shift reuses the right-shifting stages by mirroring the data on the way in and on the way out.

There is no clock and no state, so the house state-machine layout does not apply. The decode step stands in for it: each of the nine operation codes is a named decode entry. Codes 9 to 15 take the "undefined" path.

Top module: `dshift_unit`

## Requirements
- R1: Code 0 (left, immediate) gives `rt_val << shamt` with zeros entering at bit 0.
- R2: Codes 1 (left), 3 (logical right) and 5 (arithmetic right) shift by `shamt + 32`, so their distance is always in the range 32 to 63.
- R3: Codes 2, 3 and 7 are logical right shifts, and the vacated upper bits become 0.
- R4: Codes 4, 5 and 8 are arithmetic right shifts, and the vacated upper bits copy bit 63 of `rt_val`.
- R5: Codes 6 (left), 7 (logical right) and 8 (arithmetic right) take their distance from `rs_val[5:0]`, and bits 63:6 of `rs_val` have no effect on the result.
- R6: When the effective distance is 0, the result equals `rt_val` for every shift kind.
- R7: Codes 9 to 15 give a result of all zeros.
- R8: The immediate codes 0 to 5 ignore `rs_val` entirely, and the variable codes 6 to 8 ignore `shamt`.
- R9: The result is always a full 64-bit doubleword, with no truncation to 32 bits and no sign extension from bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code: 0 to 8 select the shift forms, 9 to 15 are undefined |
| rt_val | input | 64 | Operand to be shifted |
| rs_val | input | 64 | Register value; its low six bits set the distance for the variable forms |
| shamt | input | 5 | Immediate shift distance field |
| rd_val | output | 64 | Shift result |

## Verification
The checker evaluates its properties whenever the inputs change. It therefore assumes that all four inputs are driven, known values, with no X or Z bits, and that they settle together before the result is used. The bench applies every stimulus on the falling edge of its clock and samples a few nanoseconds later, so no check looks at a half-updated input set. Undefined operation codes are driven on purpose, so no assumption limits `op_sel` to 0 to 8.

// File: rtl/dshift_pkg.sv
package dshift_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LL_IMM   = 4'd0,
        OP_LL_HI    = 4'd1,
        OP_RL_IMM   = 4'd2,
        OP_RL_HI    = 4'd3,
        OP_RA_IMM   = 4'd4,
        OP_RA_HI    = 4'd5,
        OP_LL_REG   = 4'd6,
        OP_RL_REG   = 4'd7,
        OP_RA_REG   = 4'd8
    } op_t;

    typedef enum logic [1:0] {
        SRC_IMM    = 2'd0,
        SRC_IMM_HI = 2'd1,
        SRC_REG    = 2'd2
    } amt_src_t;

    typedef struct packed {
        logic     valid;
        logic     left;
        logic     arith;
        amt_src_t src;
    } shctl_t;

endpackage

// File: rtl/dshift_ctrl.sv
module dshift_ctrl
    import dshift_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    output shctl_t          ctl
);

    always_comb begin
        ctl = '{valid: 1'b0, left: 1'b0, arith: 1'b0, src: SRC_IMM};
        case (op_sel)
            OP_LL_IMM: ctl = '{valid: 1'b1, left: 1'b1, arith: 1'b0, src: SRC_IMM};
            OP_LL_HI:  ctl = '{valid: 1'b1, left: 1'b1, arith: 1'b0, src: SRC_IMM_HI};
            OP_LL_REG: ctl = '{valid: 1'b1, left: 1'b1, arith: 1'b0, src: SRC_REG};
            OP_RL_IMM: ctl = '{valid: 1'b1, left: 1'b0, arith: 1'b0, src: SRC_IMM};
            OP_RL_HI:  ctl = '{valid: 1'b1, left: 1'b0, arith: 1'b0, src: SRC_IMM_HI};
            OP_RL_REG: ctl = '{valid: 1'b1, left: 1'b0, arith: 1'b0, src: SRC_REG};
            OP_RA_IMM: ctl = '{valid: 1'b1, left: 1'b0, arith: 1'b1, src: SRC_IMM};
            OP_RA_HI:  ctl = '{valid: 1'b1, left: 1'b0, arith: 1'b1, src: SRC_IMM_HI};
            OP_RA_REG: ctl = '{valid: 1'b1, left: 1'b0, arith: 1'b1, src: SRC_REG};
            default:   ctl = '{valid: 1'b0, left: 1'b0, arith: 1'b0, src: SRC_IMM};
        endcase
    end

endmodule

// File: rtl/dshift_amt.sv
module dshift_amt
    import dshift_pkg::*;
#(
    parameter int IMM_W = 5,
    parameter int AMT_W = 6
) (
    input  amt_src_t         src,
    input  logic [IMM_W-1:0] shamt,
    input  logic [AMT_W-1:0] reg_amt,
    output logic [AMT_W-1:0] amt
);

    localparam logic [AMT_W-1:0] HI_OFFSET = AMT_W'(1) << (AMT_W - 1);

    logic [AMT_W-1:0] imm_ext;

    assign imm_ext = AMT_W'(shamt);

    always_comb begin
        unique case (src)
            SRC_IMM:    amt = imm_ext;
            SRC_IMM_HI: amt = imm_ext + HI_OFFSET;
            SRC_REG:    amt = reg_amt;
            default:    amt = '0;
        endcase
    end

endmodule

// File: rtl/dshift_barrel.sv
module dshift_barrel #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  logic              left,
    input  logic              fill,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mir_in;
    logic [DATA_W-1:0] stg [0:AMT_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_mir_in
        assign mir_in[i] = left ? din[DATA_W-1-i] : din[i];
    end

    assign stg[0] = mir_in;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][DATA_W-1:SH]} : stg[k];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_mir_out
        assign dout[i] = left ? stg[AMT_W][DATA_W-1-i] : stg[AMT_W][i];
    end

endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
    import dshift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [IMM_W-1:0]  shamt,
    output logic [DATA_W-1:0] rd_val
);

    localparam int AMT_W = $clog2(DATA_W);

    shctl_t            ctl;
    logic [AMT_W-1:0]  eff_amt;
    logic [DATA_W-1:0] shifted;
    logic              fill_bit;
    logic              unused_rs_hi;

    assign unused_rs_hi = ^rs_val[DATA_W-1:AMT_W];

    dshift_ctrl u_ctrl (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    dshift_amt #(
        .IMM_W (IMM_W),
        .AMT_W (AMT_W)
    ) u_amt (
        .src     (ctl.src),
        .shamt   (shamt),
        .reg_amt (rs_val[AMT_W-1:0]),
        .amt     (eff_amt)
    );

    assign fill_bit = ctl.arith & rt_val[DATA_W-1];

    dshift_barrel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_barrel (
        .din  (rt_val),
        .amt  (eff_amt),
        .left (ctl.left),
        .fill (fill_bit),
        .dout (shifted)
    );

    assign rd_val = ctl.valid ? shifted : '0;

endmodule

// File: rtl/dshift_unit_chk.sv
module dshift_unit_chk #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] rt_val,
    input logic [DATA_W-1:0] rs_val,
    input logic [IMM_W-1:0]  shamt,
    input logic [DATA_W-1:0] rd_val
);

    localparam int HALF = DATA_W / 2;

    logic imm_op;
    logic var_op;
    logic zero_dist;

    assign imm_op    = (op_sel == 4'd0) || (op_sel == 4'd2) || (op_sel == 4'd4);
    assign var_op    = (op_sel >= 4'd6) && (op_sel <= 4'd8);
    assign zero_dist = (imm_op && shamt == '0) || (var_op && rs_val[5:0] == 6'd0);

    always_comb begin
        AST_UNDEF_ZERO: assert (!(op_sel > 4'd8) || rd_val == '0)
            else $error("undefined op gave nonzero result"); // R7
        AST_ZERO_PASS: assert (!zero_dist || rd_val == rt_val)
            else $error("zero distance altered operand"); // R6
        AST_LEFT_LOWZERO: assert (!(op_sel == 4'd0 && shamt != '0) || rd_val[0] == 1'b0)
            else $error("left shift did not zero-fill bit 0"); // R1
        AST_HI_LEFT_LOW: assert (!(op_sel == 4'd1) || rd_val[HALF-1:0] == '0)
            else $error("left plus-32 low half not zero"); // R2
        AST_RL_HI_TOP: assert (!(op_sel == 4'd3) || rd_val[DATA_W-1:HALF] == '0)
            else $error("logical right plus-32 upper half not zero"); // R3
        AST_RA_HI_SIGN: assert (!(op_sel == 4'd5) ||
                                rd_val[DATA_W-1:HALF-1] == {(HALF+1){rt_val[DATA_W-1]}})
            else $error("arithmetic right plus-32 sign fill wrong"); // R4
    end

endmodule

bind dshift_unit dshift_unit_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
) u_chk (
    .op_sel (op_sel),
    .rt_val (rt_val),
    .rs_val (rs_val),
    .shamt  (shamt),
    .rd_val (rd_val)
);

// File: tb/dshift_unit_test.sv
module dshift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [63:0] rt_val = '0;
    logic [63:0] rs_val = '0;
    logic [4:0]  shamt = '0;
    logic [63:0] rd_val;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dshift_unit uut (
        .op_sel (op_sel),
        .rt_val (rt_val),
        .rs_val (rs_val),
        .shamt  (shamt),
        .rd_val (rd_val)
    );

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] r, input logic [4:0] s);
        int n;
        case (op)
            4'd0: return a << s;
            4'd1: begin n = int'(s) + 32; return a << n; end
            4'd2: return a >> s;
            4'd3: begin n = int'(s) + 32; return a >> n; end
            4'd4: return 64'($signed(a) >>> s);
            4'd5: begin n = int'(s) + 32; return 64'($signed(a) >>> n); end
            4'd6: return a << r[5:0];
            4'd7: return a >> r[5:0];
            4'd8: return 64'($signed(a) >>> r[5:0]);
            default: return 64'd0;
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [63:0] a,
                         input logic [63:0] r, input logic [4:0] s);
        @(negedge clk);
        op_sel = op;
        rt_val = a;
        rs_val = r;
        shamt  = s;
        #3;
    endtask

    task automatic check(input string req, input logic [63:0] exp);
        checks++;
        if (rd_val !== exp) begin
            failures++;
            $display("FAIL %s op=%0d rt=%h rs=%h sh=%0d actual=%h expected=%h",
                     req, op_sel, rt_val, rs_val, shamt, rd_val, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [3:0] op, input logic [63:0] a,
                           input logic [63:0] r, input logic [4:0] s);
        apply(op, a, r, s);
        check(req, model(op, a, r, s));
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        #3;
        check("R1 reset inputs zero", 64'd0);
    endtask

    task automatic t_imm_forms;
        run_one("R1", 4'd0, 64'h0123_4567_89AB_CDEF, 64'd0, 5'd4);
        run_one("R1", 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'd31);
        run_one("R3", 4'd2, 64'h8000_0000_0000_0001, 64'd0, 5'd1);
        run_one("R3", 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'd31);
        run_one("R4", 4'd4, 64'h8000_0000_0000_0000, 64'd0, 5'd31);
        run_one("R4", 4'd4, 64'h7FFF_0000_0000_0000, 64'd0, 5'd8);
        run_one("R9", 4'd0, 64'h0000_0000_8000_0000, 64'd0, 5'd1);
        apply(4'd2, 64'hFFFF_FFFF_0000_0000, 64'd0, 5'd0);
        check("R9 no 32-bit sign extension", 64'hFFFF_FFFF_0000_0000);
    endtask

    task automatic t_hi_forms;
        apply(4'd1, 64'h0000_0000_0000_0001, 64'd0, 5'd0);
        check("R2 left plus32 sh0", 64'h0000_0001_0000_0000);
        apply(4'd1, 64'h0000_0000_0000_0001, 64'd0, 5'd31);
        check("R2 left plus32 sh31", 64'h8000_0000_0000_0000);
        apply(4'd3, 64'h8000_0000_0000_0000, 64'd0, 5'd31);
        check("R2 R3 logical plus32 sh31", 64'd1);
        apply(4'd5, 64'h8000_0000_0000_0000, 64'd0, 5'd31);
        check("R2 R4 arith plus32 sh31", 64'hFFFF_FFFF_FFFF_FFFF);
        apply(4'd5, 64'h8000_0000_0000_0000, 64'd0, 5'd0);
        check("R2 R4 arith plus32 sh0", 64'hFFFF_FFFF_8000_0000);
        run_one("R2", 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'd0);
    endtask

    task automatic t_variable;
        apply(4'd6, 64'd1, 64'd63, 5'd0);
        check("R5 var left 63", 64'h8000_0000_0000_0000);
        apply(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32, 5'd0);
        check("R5 R3 var logical 32", 64'h0000_0000_FFFF_FFFF);
        apply(4'd8, 64'h8000_0000_0000_0000, 64'd63, 5'd0);
        check("R5 R4 var arith 63", 64'hFFFF_FFFF_FFFF_FFFF);
        apply(4'd6, 64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFC4, 5'd0);
        check("R5 upper rs ignored", 64'h0000_0000_0000_0FF0);
        apply(4'd8, 64'h8000_0000_0000_0000, 64'hABCD_0000_0000_0040, 5'd0);
        check("R5 rs bit6 ignored", 64'h8000_0000_0000_0000);
    endtask

    task automatic t_zero_distance;
        for (int op = 0; op <= 8; op++) begin
            if (op == 1 || op == 3 || op == 5) continue;
            apply(4'(op), 64'hDEAD_BEEF_8000_0001, 64'hFFFF_FFFF_FFFF_FFC0, 5'd0);
            check("R6 zero distance", 64'hDEAD_BEEF_8000_0001);
        end
    endtask

    task automatic t_undefined;
        for (int op = 9; op <= 15; op++) begin
            apply(4'(op), 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 5'd3);
            check("R7 undefined op", 64'd0);
        end
    endtask

    task automatic t_ignore;
        apply(4'd4, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 5'd4);
        check("R8 imm ignores rs", 64'hF800_0000_0000_0000);
        apply(4'd3, 64'h8000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0, 5'd0);
        check("R8 plus32 ignores rs", 64'h0000_0000_8000_0000);
        apply(4'd7, 64'h8000_0000_0000_0000, 64'd4, 5'd31);
        check("R8 var ignores shamt", 64'h0800_0000_0000_0000);
    endtask

    task automatic t_corner_sweep;
        logic [63:0] pats [2];
        pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[1] = 64'h8000_0000_0000_0000;
        for (int p = 0; p < 2; p++) begin
            for (int op = 0; op <= 8; op++) begin
                run_one("R9 corner sh31", 4'(op), pats[p], 64'd31, 5'd31);
                run_one("R9 corner sh0",  4'(op), pats[p], 64'd32, 5'd0);
                run_one("R9 corner rs63", 4'(op), pats[p], 64'd63, 5'd31);
            end
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            logic [63:0] r;
            a = {$urandom, $urandom};
            r = {$urandom, $urandom};
            run_one("R9 random", 4'($urandom_range(0, 8)), a, r, 5'($urandom));
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_imm_forms();
        t_hi_forms();
        t_variable();
        t_zero_distance();
        t_undefined();
        t_ignore();
        t_corner_sweep();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule